// File: doc/BRIEF.md
# Multi-chip ADC sampling sequencer

This block collects samples from up to four external converter chips at a steady rate and stores them for a host to read. A 32-bit period timer counts system clocks. Each time it expires, the block runs one sweep. The sweep starts at chip 0 and ends at a programmable highest chip. Within each chip it steps through eight channels in ascending order. For each channel whose bit is set in an 8-bit save mask, the block raises a one-hot conversion request and waits for the acknowledge. It then pushes the returned 16-bit result into a FIFO. Channels whose mask bit is clear are passed over without a request.

The host reaches the block through seven 16-bit registers on a small synchronous read/write port:

| Address | Register | Access |
|---|---|---|
| 0 | identification | read only |
| 1 | control | read/write |
| 2 | status | read only |
| 3 | data | read only |
| 4 | period, low half | read/write |
| 5 | period, high half | read/write |
| 6 | threshold | read/write |

The status register reports the FIFO fill level and a sticky overflow flag. Reading the data register pops the oldest sample. An interrupt is available in two modes: a plain level compare, and a one-shot mode that suits block draining by a DMA engine. The control register also drives a reset line to the chips and a standby line.

Top module: `adc_seq`

## Requirements
- R1: Reading address 0 returns 0xADC1. Addresses 1, 4, 5 and 6 read back the last value written to them. Addresses 0, 2 and 3 ignore writes. Address 7 reads 0.
- R2: While control bit 1 is set and control bit 0 is clear, a sweep starts every max(P,1) clocks, where P = {addr5, addr4}. The first conversion request appears P clocks after the clock edge that sets bit 1 (one clock when P is 0). A new period value takes effect at the next timer reload. A timer expiry that comes while a sweep is still running is dropped.
- R3: A sweep visits chips 0 up to control[7:6], in ascending order. Within each chip it visits channels 0 to 7 in ascending order, and channel n is requested only if control[8+n] is 1. The request is a one-hot vector `conv_req[chip]`, with the channel number on `conv_chan`. The request is held until `conv_ack` arrives. A channel that is masked out takes one clock and raises no request.
- R4: The result on `conv_data` is pushed into the FIFO on the acknowledge clock. Reading address 3 with `host_rd` pops the oldest sample; the sample appears on `host_rdata` during that read cycle. When the FIFO is empty, address 3 reads 0 and a read has no effect.
- R5: Status (address 2) holds the sample count in bits 14:0. Bit 15 is an overflow flag. A push into a full FIFO is dropped and sets the flag. The flag stays set until control bit 0 clears it. A pop and a push in the same clock both succeed.
- R6: While control bit 0 is 1, `chip_rst` is high. The FIFO empties, the overflow flag clears, any running sweep is abandoned and no new sweep starts.
- R7: When control bit 2 = 1 and bit 3 = 0, `irq` is high exactly while count >= threshold (address 6). When control bit 2 = 0, `irq` is low.
- R8: When control bits 2 and 3 are both 1, `irq` rises once count reaches max(threshold,1). It then stays high until that many samples have been popped, regardless of the count in between.
- R9: `standby` is high when control bit 5 is 1, or when control bit 4 is 1 and no sweep is running.
- R10: Clearing control bit 1 lets a running sweep finish. After that, no further samples are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rd | input | 1 | Read strobe (pops when addressing 3) |
| host_rdata | output | 16 | Read data for host_addr, combinational |
| conv_req | output | 4 | One-hot conversion request per chip |
| conv_chan | output | 3 | Channel being converted |
| conv_ack | input | 1 | Conversion done, result valid |
| conv_data | input | 16 | Conversion result |
| chip_rst | output | 1 | Reset to converter chips |
| standby | output | 1 | Standby request to converter chips |
| irq | output | 1 | Interrupt |

## Verification
Register writes, pops and pushes all take effect at the clock edge where their strobe is sampled. Read data, `irq` and `standby` are combinational from that state, so they are due in the same cycle the bench next observes. The first request after start is due exactly P edges after the write, and the bench counts those edges. A behavioural model with a sample queue advances on the same edges. All outputs are compared against it half a period later, when every register and input has settled. Directed checks add the sweep order decoded from drained sample words, the overflow count, and the hold-off after collection stops.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DEPTH = 16,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    host_addr,
  input  logic          host_wr,
  input  logic [15:0]   host_wdata,
  input  logic          host_rd,
  output logic [15:0]   host_rdata,
  output logic [3:0]    conv_req,
  output logic [2:0]    conv_chan,
  input  logic          conv_ack,
  input  logic [DW-1:0] conv_data,
  output logic          chip_rst,
  output logic          standby,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [15:0] ID = 16'hADC1;

  logic [15:0]   ctrl, per_lo, per_hi, thr;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          ovf, busy, sm_on;
  logic [1:0]    chip;
  logic [2:0]    ch;
  logic [31:0]   tmr;
  logic [15:0]   sm_left;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire        clr     = ctrl[0];
  wire        run     = ctrl[1] & ~clr;
  wire [7:0]  mask    = ctrl[15:8];
  wire [31:0] per     = {per_hi, per_lo};
  wire [31:0] reload  = (per == 32'd0) ? 32'd0 : per - 32'd1;
  wire        tick    = run && (tmr == 32'd0);
  wire        sel     = mask[ch];
  wire        step    = busy & (~sel | conv_ack);
  wire        push    = busy & sel & conv_ack;
  wire        pop     = host_rd && (host_addr == 3'd3) && (cnt != '0);
  wire        full    = (cnt == CW'(DEPTH));
  wire        push_ok = push & (~full | pop);
  wire [15:0] thr_eff = (thr == 16'd0) ? 16'd1 : thr;
  wire        level   = 32'(cnt) >= 32'(thr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; per_lo <= '0; per_hi <= '0; thr <= '0;
    end else if (host_wr) begin
      case (host_addr)
        3'd1: ctrl   <= host_wdata;
        3'd4: per_lo <= host_wdata;
        3'd5: per_hi <= host_wdata;
        3'd6: thr    <= host_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     tmr <= '0;
    else if (!run || tmr == 32'd0)  tmr <= reload;
    else                            tmr <= tmr - 32'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || clr) begin
      wp <= '0; rp <= '0; cnt <= '0; ovf <= 1'b0;
    end else begin
      if (pop)             rp  <= nxt(rp);
      if (push_ok)         wp  <= nxt(wp);
      if (push & ~push_ok) ovf <= 1'b1;
      cnt <= cnt + CW'(push_ok) - CW'(pop);
    end

  always_ff @(posedge clk)
    if (push_ok && !clr) mem[wp] <= conv_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; chip <= '0; ch <= '0;
    end else if (clr) begin
      busy <= 1'b0;
    end else if (!busy) begin
      if (tick) begin busy <= 1'b1; chip <= '0; ch <= '0; end
    end else if (step) begin
      if (ch == 3'd7) begin
        if (chip >= ctrl[7:6]) busy <= 1'b0;
        else begin chip <= chip + 2'd1; ch <= '0; end
      end else ch <= ch + 3'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sm_on <= 1'b0; sm_left <= '0;
    end else if (clr || !ctrl[3]) begin
      sm_on <= 1'b0;
    end else if (!sm_on) begin
      if (32'(cnt) >= 32'(thr_eff)) begin sm_on <= 1'b1; sm_left <= thr_eff; end
    end else if (pop) begin
      if (sm_left == 16'd1) sm_on <= 1'b0;
      else                  sm_left <= sm_left - 16'd1;
    end

  always_comb
    case (host_addr)
      3'd0:    host_rdata = ID;
      3'd1:    host_rdata = ctrl;
      3'd2:    host_rdata = {ovf, 15'(cnt)};
      3'd3:    host_rdata = (cnt != '0) ? 16'(mem[rp]) : 16'd0;
      3'd4:    host_rdata = per_lo;
      3'd5:    host_rdata = per_hi;
      3'd6:    host_rdata = thr;
      default: host_rdata = 16'd0;
    endcase

  assign conv_req  = (busy && sel) ? (4'b0001 << chip) : 4'b0000;
  assign conv_chan = ch;
  assign chip_rst  = clr;
  assign standby   = ctrl[5] | (ctrl[4] & ~busy);
  assign irq       = ctrl[2] & (ctrl[3] ? sm_on : level);
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   ctrl,
  input logic [15:0]   thr,
  input logic [CW-1:0] cnt,
  input logic          ovf,
  input logic          busy,
  input logic [3:0]    conv_req,
  input logic          conv_ack,
  input logic          irq,
  input logic          standby,
  input logic          host_rd,
  input logic [2:0]    host_addr
);
  p_onehot_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(conv_req));

  p_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req != 4'd0 && conv_ack && !ctrl[0] && 32'(cnt) < DEPTH &&
     !(host_rd && host_addr == 3'd3))
    |=> cnt == CW'($past(cnt) + 1'b1));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= DEPTH);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ctrl[0]) |=> ovf);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] |=> (cnt == '0 && !ovf && !busy));

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl[3]) |-> 32'(cnt) >= 32'(thr));

  p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[2] |-> !irq);

  p_force_sb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[5] |-> standby);
endmodule

bind adc_seq adc_seq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .thr(thr), .cnt(cnt), .ovf(ovf),
  .busy(busy), .conv_req(conv_req), .conv_ack(conv_ack), .irq(irq),
  .standby(standby), .host_rd(host_rd), .host_addr(host_addr)
);

// File: tb/tb_adc_seq.sv
module tb_adc_seq;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic        ack = 1'b0;
  logic [15:0] cdata = '0;
  wire  [15:0] rdata;
  wire  [3:0]  creq;
  wire  [2:0]  cch;
  wire         crst, stby, irq;

  adc_seq #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_wr(wr), .host_wdata(wdata),
    .host_rd(rd), .host_rdata(rdata), .conv_req(creq), .conv_chan(cch),
    .conv_ack(ack), .conv_data(cdata), .chip_rst(crst), .standby(stby), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit cmp_on = 0, done = 0;

  task automatic chk(bit ok, string r, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [15:0] m_ctrl = 0, m_lo = 0, m_hi = 0, m_thr = 0;
  logic [15:0] q[$];
  bit      m_ovf = 0, m_busy = 0, m_sm = 0;
  int      m_chip = 0, m_ch = 0, m_left = 0;
  longint  m_tmr = 0;

  always @(posedge clk) begin : model
    bit clr, run, tick, sel, push, pop;
    longint per, rl;
    int oldcnt, te;
    if (!rst_n) begin
      m_ctrl = 0; m_lo = 0; m_hi = 0; m_thr = 0; q.delete();
      m_ovf = 0; m_busy = 0; m_sm = 0; m_chip = 0; m_ch = 0; m_tmr = 0; m_left = 0;
    end else begin
      clr = m_ctrl[0];
      run = m_ctrl[1] && !clr;
      per = {m_hi, m_lo};
      rl = (per == 0) ? 0 : per - 1;
      tick = run && m_tmr == 0;
      sel = m_ctrl[8 + m_ch];
      push = m_busy && sel && ack;
      pop = rd && addr == 3 && q.size() != 0;
      oldcnt = q.size();
      te = (m_thr == 0) ? 1 : int'(m_thr);
      if (clr) begin q.delete(); m_ovf = 0; end
      else begin
        if (pop) void'(q.pop_front());
        if (push) begin
          if (q.size() < DEPTH) q.push_back(cdata); else m_ovf = 1;
        end
      end
      if (clr || !m_ctrl[3]) m_sm = 0;
      else if (!m_sm) begin
        if (oldcnt >= te) begin m_sm = 1; m_left = te; end
      end else if (pop) begin
        if (m_left == 1) m_sm = 0; else m_left--;
      end
      if (!run || m_tmr == 0) m_tmr = rl; else m_tmr--;
      if (clr) m_busy = 0;
      else if (!m_busy) begin
        if (tick) begin m_busy = 1; m_chip = 0; m_ch = 0; end
      end else if (!sel || ack) begin
        if (m_ch == 7) begin
          if (m_chip >= int'(m_ctrl[7:6])) m_busy = 0;
          else begin m_chip++; m_ch = 0; end
        end else m_ch++;
      end
      if (wr) case (addr)
        3'd1: m_ctrl = wdata;
        3'd4: m_lo = wdata;
        3'd5: m_hi = wdata;
        3'd6: m_thr = wdata;
        default: ;
      endcase
    end
  end

  task automatic compare();
    logic [3:0]  ereq;
    logic [15:0] erd;
    bit eirq, esb;
    ereq = (m_busy && m_ctrl[8 + m_ch]) ? (4'b0001 << m_chip) : 4'b0000;
    eirq = m_ctrl[2] && (m_ctrl[3] ? m_sm : (q.size() >= int'(m_thr)));
    esb  = m_ctrl[5] || (m_ctrl[4] && !m_busy);
    case (addr)
      3'd0: erd = 16'hADC1;
      3'd1: erd = m_ctrl;
      3'd2: erd = {m_ovf, 15'(q.size())};
      3'd3: erd = (q.size() != 0) ? q[0] : 16'd0;
      3'd4: erd = m_lo;
      3'd5: erd = m_hi;
      3'd6: erd = m_thr;
      default: erd = 16'd0;
    endcase
    chk(creq == ereq, "R3", "conv_req", creq, ereq);
    if (ereq != 0) chk(cch == 3'(m_ch), "R3", "conv_chan", cch, m_ch);
    chk(irq == eirq, "R7/R8", "irq", irq, eirq);
    chk(stby == esb, "R9", "standby", stby, esb);
    chk(crst == m_ctrl[0], "R6", "chip_rst", crst, m_ctrl[0]);
    chk(rdata == erd, "R1/R4/R5", "host_rdata", rdata, erd);
  endtask

  // converter responder
  int lat = 0, serial = 0;
  task automatic respond();
    int ci;
    if (ack) begin
      ack = 0; lat = serial % 3;
    end else if (creq != 0) begin
      if (lat == 0) begin
        ci = 0;
        for (int i = 0; i < 4; i++) if (creq[i]) ci = i;
        ack = 1;
        cdata = {2'(ci), cch, 11'(serial)};
        serial++;
      end else lat--;
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (cmp_on) compare();
    respond();
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic wreg(logic [2:0] a, logic [15:0] d);
    step(); addr = a; wdata = d; wr = 1;
    step(); wr = 0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [15:0] v);
    step(); addr = a; rd = (a == 3'd3);
    #1 v = rdata;
    step(); rd = 0;
  endtask

  function automatic logic [15:0] mkctl(logic [7:0] msk, logic [1:0] hi, bit fsb,
                                        bit isb, bit smart, bit ien, bit run, bit clr);
    return {msk, hi, fsb, isb, smart, ien, run, clr};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c1, c2;
    int n, k;
    idle(3);
    rst_n = 1;
    cmp_on = 1;
    idle(2);

    // R1 identification and reset state
    rreg(3'd0, v); chk(v == 16'hADC1, "R1", "id", v, 16'hADC1);
    rreg(3'd2, v); chk(v == 16'h0000, "R5", "status after reset", v, 0);
    rreg(3'd3, v); chk(v == 16'h0000, "R4", "empty data read", v, 0);
    wreg(3'd0, 16'h1234); rreg(3'd0, v); chk(v == 16'hADC1, "R1", "id ignores write", v, 16'hADC1);
    rreg(3'd7, v); chk(v == 0, "R1", "unused address", v, 0);

    // R3 sweep order: mask 0xA5, chips 0..2, one sweep
    wreg(3'd6, 16'd100);
    wreg(3'd4, 16'd1000);
    wreg(3'd1, mkctl(8'hA5, 2'd2, 0, 0, 0, 0, 1, 0));
    idle(1100);
    wreg(3'd1, mkctl(8'hA5, 2'd2, 0, 0, 0, 0, 0, 0));
    rreg(3'd2, v); chk(v == 16'd12, "R3", "samples per sweep", v, 12);
    k = 0;
    for (int c = 0; c <= 2; c++)
      for (int h = 0; h < 8; h++)
        if (8'hA5 & (8'h01 << h)) begin
          rreg(3'd3, v);
          chk(v[15:14] == 2'(c) && v[13:11] == 3'(h), "R3", "sweep order",
              v[15:11], {2'(c), 3'(h)});
          k++;
        end
    rreg(3'd2, v); chk(v == 0, "R4", "drained", v, 0);

    // R2 first request latency, P = 9
    wreg(3'd1, 16'h0001);
    wreg(3'd4, 16'd9);
    wreg(3'd1, mkctl(8'h01, 2'd0, 0, 0, 0, 0, 1, 0));
    n = 0;
    while (creq == 0 && n < 100) begin step(); n++; end
    chk(n == 9, "R2", "start latency P=9", n, 9);

    // R2 P = 0 behaves as 1
    wreg(3'd1, 16'h0001);
    wreg(3'd4, 16'd0);
    wreg(3'd1, mkctl(8'h01, 2'd0, 0, 0, 0, 0, 1, 0));
    n = 0;
    while (creq == 0 && n < 100) begin step(); n++; end
    chk(n == 1, "R2", "start latency P=0", n, 1);

    // R5 overflow with period change while running
    idle(200);
    wreg(3'd4, 16'd7);
    idle(100);
    rreg(3'd2, v);
    chk(v == 16'h8010, "R5", "overflow and full count", v, 16'h8010);
    rreg(3'd3, v);
    idle(50);
    rreg(3'd2, v); chk(v[15] == 1'b1, "R5", "overflow sticky", v[15], 1);

    // R10 stop collection
    wreg(3'd1, mkctl(8'h01, 2'd0, 0, 0, 0, 0, 0, 0));
    idle(30);
    rreg(3'd2, c1); idle(200); rreg(3'd2, c2);
    chk(c1 == c2, "R10", "no samples after stop", c2, c1);

    // R6 clear
    wreg(3'd1, 16'h0001);
    chk(crst == 1'b1, "R6", "chip_rst", crst, 1);
    rreg(3'd2, v); chk(v == 0, "R6", "status cleared", v, 0);

    // R7 level interrupt
    wreg(3'd6, 16'd3);
    wreg(3'd4, 16'd40);
    wreg(3'd1, mkctl(8'h03, 2'd0, 0, 0, 0, 1, 1, 0));
    idle(150);
    wreg(3'd1, mkctl(8'h03, 2'd0, 0, 0, 0, 1, 0, 0));
    idle(30);
    rreg(3'd2, v);
    chk(irq == (v[14:0] >= 3), "R7", "irq vs level", irq, v[14:0] >= 3);
    for (int i = 0; i < 20; i++) if (v[14:0] != 0) begin rreg(3'd3, c1); rreg(3'd2, v); end
    chk(irq == 1'b0, "R7", "irq after drain", irq, 0);

    // R8 smart interrupt
    wreg(3'd1, 16'h0001);
    wreg(3'd6, 16'd4);
    wreg(3'd4, 16'd300);
    wreg(3'd1, mkctl(8'h0F, 2'd0, 0, 0, 1, 1, 1, 0));
    idle(350);
    wreg(3'd1, mkctl(8'h0F, 2'd0, 0, 0, 1, 1, 0, 0));
    chk(irq == 1'b1, "R8", "smart irq raised", irq, 1);
    rreg(3'd3, v); rreg(3'd3, v); rreg(3'd3, v);
    chk(irq == 1'b1, "R8", "smart irq held below level", irq, 1);
    rreg(3'd3, v);
    chk(irq == 1'b0, "R8", "smart irq released", irq, 0);

    // R9 standby
    wreg(3'd1, mkctl(8'h0F, 2'd1, 0, 1, 0, 0, 1, 0));
    idle(20);
    chk(stby == 1'b1, "R9", "idle standby", stby, 1);
    idle(400);
    wreg(3'd1, mkctl(8'h0F, 2'd1, 1, 0, 0, 0, 0, 0));
    chk(stby == 1'b1, "R9", "forced standby", stby, 1);
    idle(5);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule